// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Core

This block is a small processor core that finishes each instruction within one clock period. It supports nine operations: register add, subtract, and, or and signed set-less-than, word load, word store, branch-if-equal and an absolute jump. The core reads its instruction and its operands, computes the result and selects the next fetch address, all combinationally. The program counter, the register file and the data memory change only at the rising clock edge.

Instruction and data storage are two separate word arrays inside the core, so a fetch and a data access can happen in the same cycle. The program counter and the branch target each have their own adder. The decode has two levels. The main decoder turns the opcode into control bits and a 2-bit operation class. A second stage combines that class with the function field and produces a 3-bit ALU code.

For test and bring-up, both arrays can be written through load ports while reset is held. A combinational debug port reads any register, and a second one reads any data word.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge, `pc` becomes 0 and all 32 registers become 0. The core writes nothing into the data array during reset.
- R2: Any instruction that is not a taken branch or a jump sets `pc` to `pc`+4 at the next edge. An opcode outside the supported set changes no register and no data word.
- R3: Opcode 000000 writes the result to register rd (bits 15:11), with rs in bits 25:21 and rt in bits 20:16. Function 100000 writes rs+rt and function 100010 writes rs−rt, both modulo 2^32.
- R4: Under opcode 000000, function 100100 writes rs AND rt and function 100101 writes rs OR rt to rd.
- R5: Under opcode 000000, function 101010 writes 1 to rd when rs is less than rt as signed 32-bit numbers, and writes 0 otherwise.
- R6: Opcode 100011 (load) writes to register rt the data word at byte address rs + sign-extended bits 15:0. The word index is address bits [DMEM_AW+1:2].
- R7: Opcode 101011 (store) writes rt into the data word at byte address rs + sign-extended bits 15:0. It changes no register.
- R8: Opcode 000100 (branch) compares rs and rt. When they are equal, `pc` becomes `pc`+4 plus the sign-extended bits 15:0 shifted left by 2. Otherwise `pc` becomes `pc`+4. Backward offsets are allowed.
- R9: Opcode 000010 (jump) sets `pc` to {(`pc`+4)[31:28], bits 25:0, 2'b00}.
- R10: Register 0 always reads 0, including after an instruction that names it as the destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_ld_we | input | 1 | Write strobe for the instruction array |
| imem_ld_addr | input | IMEM_AW | Word index for the instruction load |
| imem_ld_data | input | 32 | Instruction word to store |
| dmem_ld_we | input | 1 | Write strobe for the data array; takes priority over a core store |
| dmem_ld_addr | input | DMEM_AW | Word index for the data load |
| dmem_ld_data | input | 32 | Data word to store |
| dbg_reg_sel | input | 5 | Register number for the debug read |
| dbg_reg_data | output | 32 | Content of the selected register |
| dbg_mem_sel | input | DMEM_AW | Word index for the data debug read |
| dbg_mem_data | output | 32 | Content of the selected data word |
| pc | output | 32 | Current program counter (byte address) |

## Verification
On every cycle, the embedded assertions check how the program counter moves. After a plain instruction it must advance by four. After a taken branch it must land on the computed branch target, and after a jump on the composed jump target. The assertions also check that register 0 stays zero, that the decoder never asserts a store, a register write, a branch and a jump together, and that the counter comes out of reset at zero. What they cannot show is whether the ALU results, the load and store data and the signed comparison are correct. For those, the bench runs a program that covers every opcode and function code, a negative load offset, untaken, forward and backward branches, a jump over dead code and a write to register 0. A behavioural model steps alongside the core and is compared against it on every clock.

// File: rtl/sc_core.sv
module sc_core #(
  parameter int IMEM_AW = 6,
  parameter int DMEM_AW = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               imem_ld_we,
  input  logic [IMEM_AW-1:0] imem_ld_addr,
  input  logic [31:0]        imem_ld_data,
  input  logic               dmem_ld_we,
  input  logic [DMEM_AW-1:0] dmem_ld_addr,
  input  logic [31:0]        dmem_ld_data,
  input  logic [4:0]         dbg_reg_sel,
  output logic [31:0]        dbg_reg_data,
  input  logic [DMEM_AW-1:0] dbg_mem_sel,
  output logic [31:0]        dbg_mem_data,
  output logic [31:0]        pc
);

  localparam int IDEPTH = 1 << IMEM_AW;
  localparam int DDEPTH = 1 << DMEM_AW;

  localparam logic [5:0] OP_ALU  = 6'b000000;
  localparam logic [5:0] OP_LOAD = 6'b100011;
  localparam logic [5:0] OP_STOR = 6'b101011;
  localparam logic [5:0] OP_BEQ  = 6'b000100;
  localparam logic [5:0] OP_JMP  = 6'b000010;

  localparam logic [2:0] ALU_AND = 3'b000;
  localparam logic [2:0] ALU_OR  = 3'b001;
  localparam logic [2:0] ALU_ADD = 3'b010;
  localparam logic [2:0] ALU_SUB = 3'b110;
  localparam logic [2:0] ALU_SLT = 3'b111;

  logic [31:0] imem [IDEPTH];
  logic [31:0] dmem [DDEPTH];
  logic [31:0] rf   [32];

  logic [31:0] instr;
  logic [5:0]  opcode, funct;
  logic [4:0]  rs, rt, rd, wr_reg;
  logic [15:0] imm;
  logic [25:0] jaddr;

  logic       reg_dst, alu_src, mem_to_reg, reg_write, mem_read, mem_write, branch, jump;
  logic [1:0] alu_op;
  logic [2:0] alu_ctl;

  logic [31:0] rd1, rd2, imm_ext, alu_b, alu_res, wb_data, mem_rdata;
  logic        zero;
  logic [31:0] pc_plus4, br_target, j_target, pc_next;

  assign instr  = imem[pc[IMEM_AW+1:2]];
  assign opcode = instr[31:26];
  assign rs     = instr[25:21];
  assign rt     = instr[20:16];
  assign rd     = instr[15:11];
  assign funct  = instr[5:0];
  assign imm    = instr[15:0];
  assign jaddr  = instr[25:0];

  always_comb begin
    reg_dst    = 1'b0;
    alu_src    = 1'b0;
    mem_to_reg = 1'b0;
    reg_write  = 1'b0;
    mem_read   = 1'b0;
    mem_write  = 1'b0;
    branch     = 1'b0;
    jump       = 1'b0;
    alu_op     = 2'b00;
    case (opcode)
      OP_ALU: begin
        reg_dst   = 1'b1;
        reg_write = 1'b1;
        alu_op    = 2'b10;
      end
      OP_LOAD: begin
        alu_src    = 1'b1;
        mem_to_reg = 1'b1;
        reg_write  = 1'b1;
        mem_read   = 1'b1;
      end
      OP_STOR: begin
        alu_src   = 1'b1;
        mem_write = 1'b1;
      end
      OP_BEQ: begin
        branch = 1'b1;
        alu_op = 2'b01;
      end
      OP_JMP: jump = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    case (alu_op)
      2'b00: alu_ctl = ALU_ADD;
      2'b01: alu_ctl = ALU_SUB;
      default: begin
        case (funct)
          6'b100000: alu_ctl = ALU_ADD;
          6'b100010: alu_ctl = ALU_SUB;
          6'b100100: alu_ctl = ALU_AND;
          6'b100101: alu_ctl = ALU_OR;
          6'b101010: alu_ctl = ALU_SLT;
          default:   alu_ctl = ALU_ADD;
        endcase
      end
    endcase
  end

  assign rd1     = rf[rs];
  assign rd2     = rf[rt];
  assign imm_ext = {{16{imm[15]}}, imm};
  assign alu_b   = alu_src ? imm_ext : rd2;

  always_comb begin
    case (alu_ctl)
      ALU_AND: alu_res = rd1 & alu_b;
      ALU_OR:  alu_res = rd1 | alu_b;
      ALU_ADD: alu_res = rd1 + alu_b;
      ALU_SUB: alu_res = rd1 - alu_b;
      ALU_SLT: alu_res = {31'd0, $signed(rd1) < $signed(alu_b)};
      default: alu_res = 32'd0;
    endcase
  end

  assign zero      = (alu_res == 32'd0);
  assign mem_rdata = dmem[alu_res[DMEM_AW+1:2]];
  assign wr_reg    = reg_dst ? rd : rt;
  assign wb_data   = mem_to_reg ? mem_rdata : alu_res;

  assign pc_plus4  = pc + 32'd4;
  assign br_target = pc_plus4 + {imm_ext[29:0], 2'b00};
  assign j_target  = {pc_plus4[31:28], jaddr, 2'b00};
  assign pc_next   = jump ? j_target : ((branch && zero) ? br_target : pc_plus4);

  always_ff @(posedge clk) begin
    if (rst) pc <= 32'd0;
    else     pc <= pc_next;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 32; i++) rf[i] <= 32'd0;
    end else if (reg_write && wr_reg != 5'd0) begin
      rf[wr_reg] <= wb_data;
    end
  end

  always_ff @(posedge clk) begin
    if (dmem_ld_we)            dmem[dmem_ld_addr] <= dmem_ld_data;
    else if (!rst && mem_write) dmem[alu_res[DMEM_AW+1:2]] <= rd2;
  end

  always_ff @(posedge clk) begin
    if (imem_ld_we) imem[imem_ld_addr] <= imem_ld_data;
  end

  assign dbg_reg_data = rf[dbg_reg_sel];
  assign dbg_mem_data = dmem[dbg_mem_sel];

  logic unused_bits;
  assign unused_bits = ^{instr[10:6], pc[1:0], pc[31:IMEM_AW+2],
                         alu_res[1:0], alu_res[31:DMEM_AW+2], mem_read};

  assert_pc_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> pc == 32'd0);

  assert_seq_pc_R2: assert property (@(posedge clk) disable iff (rst)
    (!jump && !(branch && zero)) |=> pc == $past(pc) + 32'd4);

  assert_ctl_excl_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_write, reg_write, branch, jump}));

  assert_load_wb_R6: assert property (@(posedge clk) disable iff (rst)
    mem_to_reg |-> (reg_write && !reg_dst));

  assert_br_taken_R8: assert property (@(posedge clk) disable iff (rst)
    (branch && zero) |=> pc == $past(br_target));

  assert_jump_R9: assert property (@(posedge clk) disable iff (rst)
    jump |=> pc == $past(j_target));

  assert_r0_zero_R10: assert property (@(posedge clk) disable iff (rst)
    rf[0] == 32'd0);

endmodule

// File: tb/sc_core_tb.sv
module sc_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int IAW = 6;
  localparam int DAW = 6;
  localparam int RUN_CYCLES = 50;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic imem_ld_we = 1'b0;
  logic [IAW-1:0] imem_ld_addr = '0;
  logic [31:0] imem_ld_data = '0;
  logic dmem_ld_we = 1'b0;
  logic [DAW-1:0] dmem_ld_addr = '0;
  logic [31:0] dmem_ld_data = '0;
  logic [4:0] dbg_reg_sel = '0;
  logic [31:0] dbg_reg_data;
  logic [DAW-1:0] dbg_mem_sel = '0;
  logic [31:0] dbg_mem_data;
  logic [31:0] pc;

  int checks = 0;
  int fails = 0;

  logic [31:0] m_imem [64];
  logic [31:0] m_mem  [64];
  logic [31:0] m_reg  [32];
  logic [31:0] m_pc;
  string m_tag;

  sc_core #(.IMEM_AW(IAW), .DMEM_AW(DAW)) dut_i (
    .clk(clk), .rst(rst),
    .imem_ld_we(imem_ld_we), .imem_ld_addr(imem_ld_addr), .imem_ld_data(imem_ld_data),
    .dmem_ld_we(dmem_ld_we), .dmem_ld_addr(dmem_ld_addr), .dmem_ld_data(dmem_ld_data),
    .dbg_reg_sel(dbg_reg_sel), .dbg_reg_data(dbg_reg_data),
    .dbg_mem_sel(dbg_mem_sel), .dbg_mem_data(dbg_mem_data),
    .pc(pc));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] enc_r(int s, int t, int d, logic [5:0] fn);
    return {6'b000000, 5'(s), 5'(t), 5'(d), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int s, int t, int imm);
    return {op, 5'(s), 5'(t), 16'(imm)};
  endfunction
  function automatic logic [31:0] enc_j(int word);
    return {6'b000010, 26'(word)};
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic model_step();
    logic [31:0] ins, a, b, sx, pc4, nxt, adr, res;
    ins = m_imem[m_pc[7:2]];
    a = m_reg[ins[25:21]];
    b = m_reg[ins[20:16]];
    sx = {{16{ins[15]}}, ins[15:0]};
    pc4 = m_pc + 4;
    nxt = pc4;
    adr = a + sx;
    m_tag = "R2";
    case (ins[31:26])
      6'b000000: begin
        res = 0;
        case (ins[5:0])
          6'b100000: res = a + b;
          6'b100010: res = a - b;
          6'b100100: res = a & b;
          6'b100101: res = a | b;
          6'b101010: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
          default:   res = a + b;
        endcase
        if (ins[15:11] != 0) m_reg[ins[15:11]] = res;
      end
      6'b100011: if (ins[20:16] != 0) m_reg[ins[20:16]] = m_mem[adr[7:2]];
      6'b101011: m_mem[adr[7:2]] = b;
      6'b000100: begin
        m_tag = "R8";
        if (a == b) nxt = pc4 + (sx << 2);
      end
      6'b000010: begin
        m_tag = "R9";
        nxt = {pc4[31:28], ins[25:0], 2'b00};
      end
      default: ;
    endcase
    m_pc = nxt;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    for (int i = 0; i < 64; i++) begin m_imem[i] = 32'd0; m_mem[i] = 32'd0; end
    for (int i = 0; i < 32; i++) m_reg[i] = 32'd0;
    m_mem[0] = 32'd5;
    m_mem[1] = 32'hFFFF_FFFD;
    m_mem[2] = 32'h1234_5678;
    m_imem[0]  = enc_i(6'b100011, 0, 1, 0);
    m_imem[1]  = enc_i(6'b100011, 0, 2, 4);
    m_imem[2]  = enc_i(6'b100011, 0, 3, 8);
    m_imem[3]  = enc_r(1, 2, 4, 6'b100000);
    m_imem[4]  = enc_r(1, 2, 5, 6'b100010);
    m_imem[5]  = enc_r(3, 5, 6, 6'b100100);
    m_imem[6]  = enc_r(3, 1, 7, 6'b100101);
    m_imem[7]  = enc_r(2, 1, 8, 6'b101010);
    m_imem[8]  = enc_r(1, 2, 9, 6'b101010);
    m_imem[9]  = enc_i(6'b101011, 0, 4, 16);
    m_imem[10] = enc_i(6'b100011, 0, 10, 16);
    m_imem[11] = enc_r(1, 1, 0, 6'b100000);
    m_imem[12] = enc_i(6'b100011, 5, 11, -4);
    m_imem[13] = enc_i(6'b000100, 1, 2, 5);
    m_imem[14] = enc_i(6'b000100, 4, 4, 2);
    m_imem[15] = enc_r(1, 1, 13, 6'b100000);
    m_imem[16] = enc_r(1, 1, 13, 6'b100000);
    m_imem[17] = enc_j(20);
    m_imem[18] = enc_r(1, 1, 13, 6'b100000);
    m_imem[19] = enc_r(1, 1, 13, 6'b100000);
    m_imem[20] = enc_r(14, 1, 14, 6'b100000);
    m_imem[21] = enc_r(14, 5, 15, 6'b101010);
    m_imem[22] = enc_i(6'b000100, 15, 0, 1);
    m_imem[23] = enc_i(6'b000100, 0, 0, -4);
    m_imem[24] = enc_i(6'b101011, 0, 14, 20);
    m_imem[25] = enc_j(25);
    m_pc = 32'd0;

    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      imem_ld_we = 1'b1; imem_ld_addr = IAW'(i); imem_ld_data = m_imem[i];
      dmem_ld_we = 1'b1; dmem_ld_addr = DAW'(i); dmem_ld_data = m_mem[i];
    end
    @(negedge clk);
    imem_ld_we = 1'b0;
    dmem_ld_we = 1'b0;
    dbg_reg_sel = 5'd7;
    #1;
    check("R1", "pc in reset", pc, 32'd0);
    check("R1", "reg7 in reset", dbg_reg_data, 32'd0);
    rst = 1'b0;

    for (int c = 0; c < RUN_CYCLES; c++) begin
      @(posedge clk);
      model_step();
      #1;
      check(m_tag, "pc", pc, m_pc);
      dbg_reg_sel = 5'(c);
      dbg_mem_sel = DAW'(c % 8);
      #1;
      check("R3", $sformatf("reg%0d", c % 32), dbg_reg_data, m_reg[c % 32]);
      check("R7", $sformatf("mem%0d", c % 8), dbg_mem_data, m_mem[c % 8]);
    end

    for (int r = 0; r < 32; r++) begin
      dbg_reg_sel = 5'(r);
      #1;
      check("R3", $sformatf("final reg%0d", r), dbg_reg_data, m_reg[r]);
    end
    dbg_reg_sel = 5'd4;  #1; check("R3", "add r4", dbg_reg_data, 32'd2);
    dbg_reg_sel = 5'd5;  #1; check("R3", "sub r5", dbg_reg_data, 32'd8);
    dbg_reg_sel = 5'd6;  #1; check("R4", "and r6", dbg_reg_data, 32'd8);
    dbg_reg_sel = 5'd7;  #1; check("R4", "or r7", dbg_reg_data, 32'h1234_567D);
    dbg_reg_sel = 5'd8;  #1; check("R5", "slt neg<pos", dbg_reg_data, 32'd1);
    dbg_reg_sel = 5'd9;  #1; check("R5", "slt pos<neg", dbg_reg_data, 32'd0);
    dbg_reg_sel = 5'd10; #1; check("R6", "load after store", dbg_reg_data, 32'd2);
    dbg_reg_sel = 5'd11; #1; check("R6", "negative offset load", dbg_reg_data, 32'hFFFF_FFFD);
    dbg_reg_sel = 5'd0;  #1; check("R10", "r0 after write", dbg_reg_data, 32'd0);
    dbg_reg_sel = 5'd13; #1; check("R8", "skipped code r13", dbg_reg_data, 32'd0);
    dbg_reg_sel = 5'd14; #1; check("R8", "loop count r14", dbg_reg_data, 32'd10);
    dbg_mem_sel = DAW'(4); #1; check("R7", "store word4", dbg_mem_data, 32'd2);
    dbg_mem_sel = DAW'(5); #1; check("R7", "store word5", dbg_mem_data, 32'd10);
    check("R9", "parked pc", pc, 32'd100);
    report();
  end
endmodule